// File: doc/BRIEF.md
# Interrupt Pin Dispatcher

This block sits between a set of interrupt lines and the interrupt receivers downstream. Each pin has a routing entry that holds a mask, a trigger mode, a vector, a destination, a destination mode and a delivery mode. Line activity comes in as one message per cycle: a pin index and a new level. A high message is an assertion. The block reports each assertion as either accepted or coalesced. It keeps a pending bit for every pin and a remote-pending bit for every level-mode pin. From these it raises at most one delivery request at a time toward the receivers.

The downstream side accepts a request by returning a count of the destinations that took it. An edge-mode pin loses its pending bit when its request is issued. A level-mode pin becomes remote-pending, and it stays that way until an end-of-interrupt message carrying its vector arrives. If the line is still high at that point, the pin fires again. Rewriting a routing entry clears that pin's remote-pending bit, and a level-mode pin that is still pending is then serviced right away.

Top module: `pin_dispatch`

## Requirements
- R1: After reset every routing entry is masked, no pin is pending or remote-pending, and `req_valid` and `evt_valid` are low.
- R2: A line message with level 0 clears the pin's pending bit. A later end-of-interrupt or entry rewrite then delivers nothing, and the next assertion of an edge pin is accepted.
- R3: An assertion of an edge-mode pin (`cfg_trig`=0) whose pending bit is still set is reported with `evt_coalesced`=1 and produces no new request.
- R4: An assertion of a level-mode pin (`cfg_trig`=1) that is remote-pending is reported with `evt_coalesced`=1 and produces no request, but it leaves the pin pending.
- R5: A masked pin produces no request and keeps its pending bit.
- R6: Issuing a request for an edge pin clears its pending bit, so the next assertion is accepted and delivered again.
- R7: A level-mode request that is acknowledged with a nonzero `ack_count` leaves the pin remote-pending. An `ack_count` of 0 leaves it free, and the next assertion is accepted.
- R8: An end-of-interrupt clears remote-pending on every level-mode pin whose vector equals `eoi_vec`, and it re-delivers those pins that are still pending. Other vectors and edge-mode pins are unaffected.
- R9: A routing-entry write clears that pin's remote-pending bit. When the new entry is level-mode and the pin is pending, the pin is serviced immediately.
- R10: When several pins await service, the lowest-numbered pin is requested first.
- R11: While `req_valid` is high and `ack_valid` is low, `req_valid`, `req_pin`, `req_vec` and `req_dest` hold their values.
- R12: `evt_valid` and `evt_coalesced` appear in the cycle after the assertion message. A resulting request appears no earlier than the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Line-level message strobe |
| line_pin | input | IW | Pin addressed by the line message |
| line_level | input | 1 | New line level: 1 assert, 0 deassert |
| cfg_we | input | 1 | Routing-entry write strobe |
| cfg_idx | input | IW | Pin whose entry is written |
| cfg_mask | input | 1 | 1 masks the pin |
| cfg_trig | input | 1 | Trigger mode: 0 edge, 1 level |
| cfg_vec | input | VW | Vector |
| cfg_dest | input | DW | Destination |
| cfg_dmode | input | 1 | Destination mode |
| cfg_dlv | input | DLW | Delivery mode |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | VW | Vector being acknowledged |
| req_valid | output | 1 | Delivery request outstanding |
| req_pin | output | IW | Pin being delivered |
| req_vec | output | VW | Vector of the request |
| req_dest | output | DW | Destination of the request |
| req_dmode | output | 1 | Destination mode of the request |
| req_trig | output | 1 | Trigger mode of the request |
| req_dlv | output | DLW | Delivery mode of the request |
| ack_valid | input | 1 | Downstream acknowledge of the request |
| ack_count | input | CW | Number of destinations that accepted |
| evt_valid | output | 1 | Assertion report strobe |
| evt_pin | output | IW | Pin of the reported assertion |
| evt_coalesced | output | 1 | 1 coalesced, 0 accepted |

## Verification
An assertion of a level pin and an end-of-interrupt for that pin's vector can land in the same cycle. The bench provokes this by driving both strobes together while the pin is remote-pending. The assertion must be judged coalesced against the state at the start of that cycle. The end-of-interrupt must still clear remote-pending, see the pin as pending and fire one new request, so the bench expects a coalesced report that is followed by a request for that pin.

// File: rtl/pin_dispatch.sv
module pin_dispatch #(
  parameter int NPIN = 8,
  parameter int VW   = 8,
  parameter int DW   = 8,
  parameter int DLW  = 3,
  parameter int CW   = 4,
  localparam int IW  = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_valid,
  input  logic [IW-1:0]  line_pin,
  input  logic           line_level,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic           cfg_mask,
  input  logic           cfg_trig,
  input  logic [VW-1:0]  cfg_vec,
  input  logic [DW-1:0]  cfg_dest,
  input  logic           cfg_dmode,
  input  logic [DLW-1:0] cfg_dlv,
  input  logic           eoi_valid,
  input  logic [VW-1:0]  eoi_vec,
  output logic           req_valid,
  output logic [IW-1:0]  req_pin,
  output logic [VW-1:0]  req_vec,
  output logic [DW-1:0]  req_dest,
  output logic           req_dmode,
  output logic           req_trig,
  output logic [DLW-1:0] req_dlv,
  input  logic           ack_valid,
  input  logic [CW-1:0]  ack_count,
  output logic           evt_valid,
  output logic [IW-1:0]  evt_pin,
  output logic           evt_coalesced
);

  logic [NPIN-1:0] e_mask, e_trig, e_dmode;
  logic [VW-1:0]   e_vec  [NPIN];
  logic [DW-1:0]   e_dest [NPIN];
  logic [DLW-1:0]  e_dlv  [NPIN];

  logic [NPIN-1:0] pend, rirr, svc;
  logic [NPIN-1:0] pend_n, rirr_n, svc_n;

  logic [IW-1:0] gsel;
  logic          gany, issue, coal;

  wire ack_fire = req_valid & ack_valid;
  wire line_ok  = {{(32-IW){1'b0}}, line_pin} < NPIN;
  wire cfg_ok   = {{(32-IW){1'b0}}, cfg_idx}  < NPIN;

  always_comb begin
    gsel = '0;
    gany = 1'b0;
    for (int i = NPIN-1; i >= 0; i--)
      if (svc[i]) begin
        gsel = IW'(i);
        gany = 1'b1;
      end
  end

  always_comb begin
    pend_n = pend;
    rirr_n = rirr;
    svc_n  = svc;
    issue  = 1'b0;
    coal   = 1'b0;

    if (ack_fire && req_trig && ack_count == '0)
      rirr_n[req_pin] = 1'b0;

    if (!req_valid && gany) begin
      svc_n[gsel] = 1'b0;
      if (pend[gsel] && !e_mask[gsel] && !(e_trig[gsel] && rirr[gsel])) begin
        issue = 1'b1;
        if (e_trig[gsel]) rirr_n[gsel] = 1'b1;
        else              pend_n[gsel] = 1'b0;
      end
    end

    if (line_valid && line_ok) begin
      if (!line_level) begin
        pend_n[line_pin] = 1'b0;
      end else begin
        coal = e_trig[line_pin] ? rirr_n[line_pin] : pend_n[line_pin];
        pend_n[line_pin] = 1'b1;
        if (!coal) svc_n[line_pin] = 1'b1;
      end
    end

    if (eoi_valid)
      for (int i = 0; i < NPIN; i++)
        if (e_trig[i] && e_vec[i] == eoi_vec) begin
          rirr_n[i] = 1'b0;
          if (pend_n[i]) svc_n[i] = 1'b1;
        end

    if (cfg_we && cfg_ok) begin
      rirr_n[cfg_idx] = 1'b0;
      if (cfg_trig && pend_n[cfg_idx]) svc_n[cfg_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      rirr <= '0;
      svc  <= '0;
    end else begin
      pend <= pend_n;
      rirr <= rirr_n;
      svc  <= svc_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_mask  <= '1;
      e_trig  <= '0;
      e_dmode <= '0;
      for (int i = 0; i < NPIN; i++) begin
        e_vec[i]  <= '0;
        e_dest[i] <= '0;
        e_dlv[i]  <= '0;
      end
    end else if (cfg_we && cfg_ok) begin
      e_mask[cfg_idx]  <= cfg_mask;
      e_trig[cfg_idx]  <= cfg_trig;
      e_dmode[cfg_idx] <= cfg_dmode;
      e_vec[cfg_idx]   <= cfg_vec;
      e_dest[cfg_idx]  <= cfg_dest;
      e_dlv[cfg_idx]   <= cfg_dlv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_pin   <= '0;
      req_vec   <= '0;
      req_dest  <= '0;
      req_dmode <= 1'b0;
      req_trig  <= 1'b0;
      req_dlv   <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_pin   <= gsel;
      req_vec   <= e_vec[gsel];
      req_dest  <= e_dest[gsel];
      req_dmode <= e_dmode[gsel];
      req_trig  <= e_trig[gsel];
      req_dlv   <= e_dlv[gsel];
    end else if (ack_fire) begin
      req_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid     <= 1'b0;
      evt_pin       <= '0;
      evt_coalesced <= 1'b0;
    end else begin
      evt_valid     <= line_valid & line_ok & line_level;
      evt_pin       <= line_pin;
      evt_coalesced <= coal;
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ack_valid |=> req_valid && $stable(req_pin) && $stable(req_vec) && $stable(req_dest));

  // R7
  lvl_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_trig && !$past(eoi_valid) && !$past(cfg_we) |-> rirr[req_pin]);

  // R6
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && !req_trig && !$past(line_valid) |-> !pend[req_pin]);

  // R3
  edge_coal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && line_level && line_ok && req_valid && !e_trig[line_pin] && pend[line_pin]
      |=> evt_valid && evt_coalesced);

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && gany && e_mask[gsel] |=> !req_valid);

endmodule

// File: tb/sim_pin_dispatch.sv
module sim_pin_dispatch;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_valid = 0, line_level = 0;
  logic [2:0] line_pin = 0;
  logic       cfg_we = 0, cfg_mask = 0, cfg_trig = 0, cfg_dmode = 0;
  logic [2:0] cfg_idx = 0, cfg_dlv = 0;
  logic [7:0] cfg_vec = 0, cfg_dest = 0;
  logic       eoi_valid = 0;
  logic [7:0] eoi_vec = 0;
  logic       req_valid, req_dmode, req_trig;
  logic [2:0] req_pin, req_dlv;
  logic [7:0] req_vec, req_dest;
  logic       ack_valid = 0;
  logic [3:0] ack_count = 0;
  logic       evt_valid, evt_coalesced;
  logic [2:0] evt_pin;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_dispatch u0 (
    .clk(clk), .rst_n(rst_n),
    .line_valid(line_valid), .line_pin(line_pin), .line_level(line_level),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_mask(cfg_mask), .cfg_trig(cfg_trig),
    .cfg_vec(cfg_vec), .cfg_dest(cfg_dest), .cfg_dmode(cfg_dmode), .cfg_dlv(cfg_dlv),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .req_valid(req_valid), .req_pin(req_pin), .req_vec(req_vec), .req_dest(req_dest),
    .req_dmode(req_dmode), .req_trig(req_trig), .req_dlv(req_dlv),
    .ack_valid(ack_valid), .ack_count(ack_count),
    .evt_valid(evt_valid), .evt_pin(evt_pin), .evt_coalesced(evt_coalesced)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic cfg(input int p, input bit m, input bit t, input logic [7:0] v, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(p); cfg_mask = m; cfg_trig = t; cfg_vec = v; cfg_dest = d;
    cfg_dmode = 1'b1; cfg_dlv = 3'd2;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic line(input int p, input bit lvl);
    @(negedge clk);
    line_valid = 1; line_pin = 3'(p); line_level = lvl;
    @(negedge clk);
    line_valid = 0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1; eoi_vec = v;
    @(negedge clk);
    eoi_valid = 0;
  endtask

  task automatic evt_is(input string r, input bit coal);
    chk({r, " evt_valid"}, 32'(evt_valid), 32'd1);
    chk({r, " evt_coalesced"}, 32'(evt_coalesced), 32'(coal));
  endtask

  task automatic take(input string r, input int p, input logic [7:0] v, input logic [3:0] cnt, input bit do_ack);
    for (int k = 0; k < 6 && !req_valid; k++) @(negedge clk);
    chk({r, " req_valid"}, 32'(req_valid), 32'd1);
    chk({r, " req_pin"}, 32'(req_pin), 32'(p));
    chk({r, " req_vec"}, 32'(req_vec), 32'(v));
    if (do_ack) begin
      ack_valid = 1; ack_count = cnt;
      @(negedge clk);
      ack_valid = 0;
    end
  endtask

  task automatic none(input string r, input int n);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (req_valid) seen = 1;
    end
    chk({r, " no request"}, 32'(seen), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 req_valid after reset", 32'(req_valid), 32'd0);
    chk("R1 evt_valid after reset", 32'(evt_valid), 32'd0);
    line(0, 1);
    evt_is("R1 default entry", 1'b0);
    none("R1 default masked", 5);
    line(0, 0);
  endtask

  task automatic t_edge();
    cfg(1, 0, 0, 8'h31, 8'h05);
    line(1, 1);
    evt_is("R12 edge assert", 1'b0);
    chk("R12 request not yet", 32'(req_valid), 32'd0);
    take("R6 first edge", 1, 8'h31, 4'd1, 1'b0);
    chk("R6 req_dest", 32'(req_dest), 32'h05);
    chk("R6 req_trig edge", 32'(req_trig), 32'd0);
    ack_valid = 1; ack_count = 4'd1;
    @(negedge clk);
    ack_valid = 0;
    line(1, 0);
    line(1, 1);
    evt_is("R6 re-assert", 1'b0);
    take("R6 second edge", 1, 8'h31, 4'd1, 1'b1);
    eoi(8'h31);
    none("R8 edge pin ignores eoi", 5);
  endtask

  task automatic t_edge_coal();
    cfg(2, 1, 0, 8'h32, 8'h02);
    line(2, 1);
    evt_is("R5 masked edge accepted", 1'b0);
    line(2, 1);
    evt_is("R3 edge coalesced", 1'b1);
    none("R5 masked edge", 5);
    line(2, 0);
    line(2, 1);
    evt_is("R2 cleared then accepted", 1'b0);
    line(2, 0);
  endtask

  task automatic t_level();
    cfg(3, 1, 1, 8'h33, 8'h03);
    line(3, 1);
    evt_is("R5 masked level", 1'b0);
    none("R5 masked level", 5);
    cfg(3, 0, 1, 8'h33, 8'h03);
    take("R9 unmask services pending", 3, 8'h33, 4'd2, 1'b1);
    line(3, 1);
    evt_is("R4 remote-pending coalesced", 1'b1);
    none("R4 no delivery", 5);
    eoi(8'h99);
    none("R8 other vector", 5);
    eoi(8'h33);
    take("R8 eoi redelivers", 3, 8'h33, 4'd0, 1'b1);
    line(3, 1);
    evt_is("R7 zero count leaves free", 1'b0);
    take("R7 zero count redelivery", 3, 8'h33, 4'd1, 1'b1);
    line(3, 0);
    eoi(8'h33);
    none("R2 deasserted level", 5);
    line(3, 1);
    evt_is("R8 eoi cleared remote", 1'b0);
    take("R8 after eoi", 3, 8'h33, 4'd1, 1'b1);
    cfg(3, 0, 1, 8'h33, 8'h03);
    take("R9 rewrite clears remote", 3, 8'h33, 4'd1, 1'b1);
    line(3, 0);
  endtask

  task automatic t_prio();
    bit moved = 0;
    cfg(4, 0, 0, 8'h44, 8'h04);
    cfg(5, 0, 0, 8'h45, 8'h04);
    cfg(6, 0, 0, 8'h46, 8'h04);
    line(6, 1);
    take("R10 hold pin6", 6, 8'h46, 4'd1, 1'b0);
    line(5, 1);
    line(4, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (!req_valid || req_pin != 3'd6 || req_vec != 8'h46) moved = 1;
    end
    chk("R11 request held", 32'(moved), 32'd0);
    ack_valid = 1; ack_count = 4'd1;
    @(negedge clk);
    ack_valid = 0;
    take("R10 lowest first", 4, 8'h44, 4'd1, 1'b1);
    take("R10 next", 5, 8'h45, 4'd1, 1'b1);
    line(4, 0); line(5, 0); line(6, 0);
  endtask

  task automatic t_collide();
    cfg(7, 0, 1, 8'h77, 8'h07);
    line(7, 1);
    take("R8 collide setup", 7, 8'h77, 4'd1, 1'b1);
    @(negedge clk);
    line_valid = 1; line_pin = 3'd7; line_level = 1'b1;
    eoi_valid = 1; eoi_vec = 8'h77;
    @(negedge clk);
    line_valid = 0; eoi_valid = 0;
    evt_is("R4 same-cycle assert", 1'b1);
    take("R8 same-cycle eoi fires", 7, 8'h77, 4'd1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edge();
    t_edge_coal();
    t_level();
    t_prio();
    t_collide();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule